// File: doc/BRIEF.md
# Register File with Pointer Address Unit

This block holds the working registers of a small 8-bit processor core. It has thirty-two 8-bit registers, two combinational read ports that feed the ALU operands, and one write port that takes the ALU result. The six highest registers also form three 16-bit address pointers: X, Y and Z. Each pointer is built from a fixed pair of adjacent registers, with the odd register as the high byte.

An address-generation port picks one pointer and one of four modes: plain, displacement, post-increment or pre-decrement. In the same cycle it returns the effective data address. When the mode changes the pointer, the new value goes back into the register pair at the next clock edge. Byte writes and pointer updates go to the same storage, so a pointer can be loaded one byte at a time through the normal write port.

The ALU, the instruction decoder, the data memories and the external bus sit around this block. They are not part of it.

Top module: `regfile_ptr_unit`

## Requirements
- R1: A synchronous active-high reset sets every one of the 32 registers to zero at the clock edge where `rst` is high.
- R2: When `wr_en` is high, `wr_data` is stored in register `wr_sel` at the rising edge. Both read ports return the contents of the register they select, combinationally.
- R3: X is the value {r27,r26}, Y is {r29,r28} and Z is {r31,r30}. On `ag_sel`, code 0 picks X, code 1 picks Y and code 2 picks Z. On `ptr_view`, X is at bits [15:0], Y at [31:16] and Z at [47:32].
- R4: Plain mode (`ag_mode`=0) returns the selected pointer as the address and leaves the pointer unchanged.
- R5: Displacement mode (`ag_mode`=1) returns the pointer plus the 6-bit unsigned `ag_disp`, wrapping modulo 2^16. The pointer is unchanged.
- R6: Post-increment mode (`ag_mode`=2) returns the current pointer value. At the edge, the pointer becomes that value plus one, wrapping modulo 2^16.
- R7: Pre-decrement mode (`ag_mode`=3) returns the pointer minus one, wrapping modulo 2^16. At the edge, that same value is stored as the pointer.
- R8: If a pointer writeback and an ALU write target the same register in the same cycle, the register takes the pointer byte. An ALU write to any other register in that cycle still takes effect.
- R9: Reads and pointer views show the contents from before the edge. A value written or updated in one cycle becomes visible only in the next cycle.
- R10: When `ag_en` is low, or when `ag_sel` is the unused code 3, `ag_addr` is zero and no register changes because of the address port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Read port A data (combinational) |
| rd_b_sel | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Read port B data (combinational) |
| wr_en | input | 1 | ALU result write enable |
| wr_sel | input | 5 | Register index for the ALU write |
| wr_data | input | 8 | ALU result data |
| ag_en | input | 1 | Address generation request |
| ag_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 unused |
| ag_mode | input | 2 | 0 plain, 1 displacement, 2 post-increment, 3 pre-decrement |
| ag_disp | input | 6 | Unsigned displacement |
| ag_addr | output | 16 | Effective data address (combinational) |
| ptr_view | output | 48 | Current X, Y and Z pointer values |

## Verification
The assertions check the address rules on every cycle:
- the post-increment and pre-decrement addresses and the pointer value that follows each one;
- the displacement sum, and that the pointer holds steady in that mode;
- the zero address when idle;
- the rule that the pointer wins a same-register collision with the ALU.

Some behaviour only the bench scenarios can show:
- the reset clearing every register;
- the byte ordering of each register pair;
- that a read shows the value from before the edge;
- wrap-around at 0x0000 and 0xFFFF;
- that the unused select code leaves all pointers untouched.

// File: rtl/regfile_ptr_pkg.sv
`timescale 1ns/1ps
package regfile_ptr_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_DISP    = 2'd1,
    AM_POSTINC = 2'd2,
    AM_PREDEC  = 2'd3
  } agu_mode_e;

  // Register index of the low byte of pointer p
  function automatic int ptr_lo_idx(input int base, input int p);
    return base + 2 * p;
  endfunction

  // Register index of the high byte of pointer p
  function automatic int ptr_hi_idx(input int base, input int p);
    return base + 2 * p + 1;
  endfunction

endpackage

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage
  import regfile_ptr_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int NPTR     = 3,
  parameter int PTR_BASE = 26,
  localparam int SEL_W   = $clog2(NREGS),
  localparam int AW      = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alu_we,
  input  logic [SEL_W-1:0]          alu_sel,
  input  logic [DW-1:0]             alu_data,
  input  logic [NPTR-1:0]           ptr_we,
  input  logic [NPTR-1:0][AW-1:0]   ptr_val,
  output logic [NREGS*DW-1:0]       regs_flat
);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam int RI = r;
    logic [DW-1:0] q;
    logic [DW-1:0] nxt;

    // Each register picks its next value; a pointer writeback overrides the ALU
    always_comb begin
      nxt = q;
      if (alu_we && (alu_sel == SEL_W'(RI))) begin
        nxt = alu_data;
      end
      for (int p = 0; p < NPTR; p++) begin
        if (ptr_we[p] && (RI == ptr_lo_idx(PTR_BASE, p))) begin
          nxt = ptr_val[p][DW-1:0];
        end
        if (ptr_we[p] && (RI == ptr_hi_idx(PTR_BASE, p))) begin
          nxt = ptr_val[p][AW-1:DW];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        q <= nxt;
      end
    end

    assign regs_flat[RI*DW +: DW] = q;
  end

endmodule

// File: rtl/rf_read_mux.sv
`timescale 1ns/1ps
module rf_read_mux #(
  parameter int NREGS  = 32,
  parameter int DW     = 8,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic [NREGS*DW-1:0] regs_flat,
  input  logic [SEL_W-1:0]    sel,
  output logic [DW-1:0]       data
);

  always_comb begin
    data = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (sel == SEL_W'(r)) begin
        data = regs_flat[r*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/ptr_agu.sv
`timescale 1ns/1ps
module ptr_agu
  import regfile_ptr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NPTR    = 3,
  parameter int DISP_W  = 6,
  localparam int AW     = 2 * DW,
  localparam int PSEL_W = $clog2(NPTR + 1)
) (
  input  logic                    en,
  input  logic [PSEL_W-1:0]       sel,
  input  logic [1:0]              mode,
  input  logic [DISP_W-1:0]       disp,
  input  logic [NPTR-1:0][AW-1:0] views,
  output logic [AW-1:0]           addr,
  output logic [NPTR-1:0]         wb_en,
  output logic [NPTR-1:0][AW-1:0] wb_val
);

  agu_mode_e     mode_e;
  logic          hit;
  logic [AW-1:0] cur;
  logic [AW-1:0] inc_v;
  logic [AW-1:0] dec_v;
  logic [AW-1:0] dsp_v;
  logic          changes;
  logic [AW-1:0] new_v;

  assign mode_e = agu_mode_e'(mode);

  // Select the requested pointer; an unused code selects nothing
  always_comb begin
    hit = 1'b0;
    cur = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (en && (sel == PSEL_W'(p))) begin
        hit = 1'b1;
        cur = views[p];
      end
    end
  end

  assign inc_v = cur + AW'(1);
  assign dec_v = cur - AW'(1);
  assign dsp_v = cur + AW'(disp);

  always_comb begin
    addr    = '0;
    changes = 1'b0;
    new_v   = cur;
    if (hit) begin
      unique case (mode_e)
        AM_PLAIN:   addr = cur;
        AM_DISP:    addr = dsp_v;
        AM_POSTINC: begin
          addr    = cur;
          changes = 1'b1;
          new_v   = inc_v;
        end
        AM_PREDEC:  begin
          addr    = dec_v;
          changes = 1'b1;
          new_v   = dec_v;
        end
        default:    addr = cur;
      endcase
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_wb
    assign wb_en[p]  = changes && (sel == PSEL_W'(p));
    assign wb_val[p] = new_v;
  end

endmodule

// File: rtl/regfile_ptr_unit.sv
`timescale 1ns/1ps
module regfile_ptr_unit
  import regfile_ptr_pkg::*;
#(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int NPTR     = 3,
  parameter int PTR_BASE = 26,
  parameter int DISP_W   = 6,
  localparam int SEL_W   = $clog2(NREGS),
  localparam int AW      = 2 * DW,
  localparam int PSEL_W  = $clog2(NPTR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   rd_a_sel,
  output logic [DW-1:0]      rd_a_data,
  input  logic [SEL_W-1:0]   rd_b_sel,
  output logic [DW-1:0]      rd_b_data,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic               ag_en,
  input  logic [PSEL_W-1:0]  ag_sel,
  input  logic [1:0]         ag_mode,
  input  logic [DISP_W-1:0]  ag_disp,
  output logic [AW-1:0]      ag_addr,
  output logic [NPTR*AW-1:0] ptr_view
);

  logic [NREGS*DW-1:0]     regs_flat;
  logic [NPTR-1:0][AW-1:0] views;
  logic [NPTR-1:0]         wb_en;
  logic [NPTR-1:0][AW-1:0] wb_val;
  logic [1:0][SEL_W-1:0]   rd_sel;
  logic [1:0][DW-1:0]      rd_data;

  rf_storage #(
    .NREGS(NREGS), .DW(DW), .NPTR(NPTR), .PTR_BASE(PTR_BASE)
  ) u_store (
    .clk(clk), .rst(rst),
    .alu_we(wr_en), .alu_sel(wr_sel), .alu_data(wr_data),
    .ptr_we(wb_en), .ptr_val(wb_val),
    .regs_flat(regs_flat)
  );

  // Pointer views built from their fixed register pairs
  for (genvar p = 0; p < NPTR; p++) begin : g_view
    localparam int LO = ptr_lo_idx(PTR_BASE, p);
    localparam int HI = ptr_hi_idx(PTR_BASE, p);
    assign views[p] = {regs_flat[HI*DW +: DW], regs_flat[LO*DW +: DW]};
    assign ptr_view[p*AW +: AW] = views[p];
  end

  assign rd_sel[0] = rd_a_sel;
  assign rd_sel[1] = rd_b_sel;

  for (genvar k = 0; k < 2; k++) begin : g_rd
    rf_read_mux #(.NREGS(NREGS), .DW(DW)) u_rd (
      .regs_flat(regs_flat), .sel(rd_sel[k]), .data(rd_data[k])
    );
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  ptr_agu #(.DW(DW), .NPTR(NPTR), .DISP_W(DISP_W)) u_agu (
    .en(ag_en), .sel(ag_sel), .mode(ag_mode), .disp(ag_disp),
    .views(views), .addr(ag_addr), .wb_en(wb_en), .wb_val(wb_val)
  );

endmodule

// File: rtl/regfile_ptr_chk.sv
`timescale 1ns/1ps
module regfile_ptr_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [4:0]  wr_sel,
  input logic        ag_en,
  input logic [1:0]  ag_sel,
  input logic [1:0]  ag_mode,
  input logic [5:0]  ag_disp,
  input logic [15:0] ag_addr,
  input logic [47:0] ptr_view
);

  logic [15:0] px, py, pz;
  assign px = ptr_view[15:0];
  assign py = ptr_view[31:16];
  assign pz = ptr_view[47:32];

  // R6: post-increment returns the old X, then X advances by one
  a_r6_postinc_addr: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd0 && ag_mode == 2'd2) |-> (ag_addr == px));
  a_r6_postinc_next: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd0 && ag_mode == 2'd2) |=> (px == $past(px) + 16'd1));

  // R7: pre-decrement on Y returns and stores the pointer minus one
  a_r7_predec_addr: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd1 && ag_mode == 2'd3) |-> (ag_addr == py - 16'd1));
  a_r7_predec_next: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd1 && ag_mode == 2'd3) |=> (py == $past(py) - 16'd1));

  // R5: displacement on Z adds the offset and leaves Z alone
  a_r5_disp_addr: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd2 && ag_mode == 2'd1) |-> (ag_addr == pz + {10'd0, ag_disp}));
  a_r5_disp_hold: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd2 && ag_mode == 2'd1 && !wr_en) |=> $stable(pz));

  // R8: pointer writeback beats an ALU write to the X low byte
  a_r8_ptr_wins: assert property (@(posedge clk) disable iff (rst)
    (ag_en && ag_sel == 2'd0 && ag_mode == 2'd2 && wr_en && wr_sel == 5'd26)
    |=> (px == $past(px) + 16'd1));

  // R10: no request gives a zero address
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!ag_en || ag_sel == 2'd3) |-> (ag_addr == 16'd0));

endmodule

bind regfile_ptr_unit regfile_ptr_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .ag_en(ag_en), .ag_sel(ag_sel), .ag_mode(ag_mode), .ag_disp(ag_disp),
  .ag_addr(ag_addr), .ptr_view(ptr_view)
);

// File: tb/regfile_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module regfile_ptr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, ag_en = 1'b0;
  logic [1:0]  ag_sel = '0, ag_mode = '0;
  logic [5:0]  ag_disp = '0;
  logic [15:0] ag_addr;
  logic [47:0] ptr_view;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  regfile_ptr_unit dut_i (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ag_en(ag_en), .ag_sel(ag_sel), .ag_mode(ag_mode), .ag_disp(ag_disp),
    .ag_addr(ag_addr), .ptr_view(ptr_view)
  );

  function automatic logic [15:0] pv(input int p);
    return ptr_view[p*16 +: 16];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_ptr(input int p, input logic [15:0] v);
    wr(5'(26 + 2 * p), v[7:0]);
    wr(5'(27 + 2 * p), v[15:8]);
  endtask

  task automatic rd(input logic [4:0] s, output logic [7:0] d);
    rd_a_sel = s;
    #1;
    d = rd_a_data;
  endtask

  // Drive one address request, sample the address mid-cycle, then clock it
  task automatic agu(input logic [1:0] s, input logic [1:0] m, input logic [5:0] d,
                     output logic [15:0] a);
    ag_en = 1'b1; ag_sel = s; ag_mode = m; ag_disp = d;
    #1;
    a = ag_addr;
    step();
    ag_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 X after reset", pv(0), 16'h0000);
    chk("R1 Z after reset", pv(2), 16'h0000);
    wr(5'd5, 8'hAA);
    rd(5'd5, d);
    chk("R2 r5 written", {8'h0, d}, 16'h00AA);
    rst = 1'b1;
    step();
    rst = 1'b0;
    rd(5'd5, d);
    chk("R1 r5 cleared", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_alu_rw();
    wr(5'd3, 8'h5A);
    wr(5'd4, 8'hC3);
    rd_a_sel = 5'd3; rd_b_sel = 5'd4;
    #1;
    chk("R2 port A", {8'h0, rd_a_data}, 16'h005A);
    chk("R2 port B", {8'h0, rd_b_data}, 16'h00C3);
  endtask

  task automatic t_visibility();
    logic [7:0] d;
    wr(5'd7, 8'h11);
    wr_en = 1'b1; wr_sel = 5'd7; wr_data = 8'h22;
    rd(5'd7, d);
    chk("R9 old value before edge", {8'h0, d}, 16'h0011);
    step();
    wr_en = 1'b0;
    rd(5'd7, d);
    chk("R9 new value after edge", {8'h0, d}, 16'h0022);
  endtask

  task automatic t_views();
    logic [15:0] a;
    set_ptr(0, 16'h1234);
    set_ptr(1, 16'hBEEF);
    set_ptr(2, 16'h0F0E);
    chk("R3 X view", pv(0), 16'h1234);
    chk("R3 Y view", pv(1), 16'hBEEF);
    chk("R3 Z view", pv(2), 16'h0F0E);
    agu(2'd1, 2'd0, 6'd9, a);
    chk("R4 plain Y addr", a, 16'hBEEF);
    chk("R4 plain Y unchanged", pv(1), 16'hBEEF);
  endtask

  task automatic t_disp();
    logic [15:0] a;
    set_ptr(2, 16'hFFF0);
    agu(2'd2, 2'd1, 6'h3F, a);
    chk("R5 disp wrap addr", a, 16'h002F);
    chk("R5 disp Z unchanged", pv(2), 16'hFFF0);
    agu(2'd2, 2'd1, 6'h00, a);
    chk("R5 zero disp addr", a, 16'hFFF0);
  endtask

  task automatic t_postinc();
    logic [15:0] a;
    logic [7:0] d;
    set_ptr(0, 16'h12FF);
    ag_en = 1'b1; ag_sel = 2'd0; ag_mode = 2'd2;
    #1;
    chk("R9 X unchanged in request cycle", pv(0), 16'h12FF);
    ag_en = 1'b0;
    agu(2'd0, 2'd2, 6'd0, a);
    chk("R6 postinc addr", a, 16'h12FF);
    chk("R6 postinc X", pv(0), 16'h1300);
    rd(5'd27, d);
    chk("R6 carry into r27", {8'h0, d}, 16'h0013);
    set_ptr(0, 16'hFFFF);
    agu(2'd0, 2'd2, 6'd0, a);
    chk("R6 postinc wrap addr", a, 16'hFFFF);
    chk("R6 postinc wrap X", pv(0), 16'h0000);
  endtask

  task automatic t_predec();
    logic [15:0] a;
    set_ptr(1, 16'h0000);
    agu(2'd1, 2'd3, 6'd0, a);
    chk("R7 predec wrap addr", a, 16'hFFFF);
    chk("R7 predec wrap Y", pv(1), 16'hFFFF);
    set_ptr(1, 16'h0100);
    agu(2'd1, 2'd3, 6'd0, a);
    chk("R7 predec addr", a, 16'h00FF);
    chk("R7 predec Y", pv(1), 16'h00FF);
  endtask

  task automatic t_conflict();
    logic [15:0] a;
    logic [7:0] d;
    set_ptr(0, 16'h2040);
    wr_en = 1'b1; wr_sel = 5'd26; wr_data = 8'h99;
    agu(2'd0, 2'd2, 6'd0, a);
    wr_en = 1'b0;
    chk("R8 pointer wins low byte", pv(0), 16'h2041);
    set_ptr(1, 16'h3000);
    wr_en = 1'b1; wr_sel = 5'd5; wr_data = 8'h77;
    agu(2'd1, 2'd3, 6'd0, a);
    wr_en = 1'b0;
    chk("R8 Y updated", pv(1), 16'h2FFF);
    rd(5'd5, d);
    chk("R8 other reg written", {8'h0, d}, 16'h0077);
  endtask

  task automatic t_idle();
    logic [15:0] a;
    set_ptr(0, 16'h4444);
    ag_sel = 2'd0; ag_mode = 2'd2; ag_en = 1'b0;
    #1;
    a = ag_addr;
    step();
    chk("R10 disabled addr", a, 16'h0000);
    chk("R10 disabled X kept", pv(0), 16'h4444);
    agu(2'd3, 2'd3, 6'd5, a);
    chk("R10 code 3 addr", a, 16'h0000);
    chk("R10 code 3 X kept", pv(0), 16'h4444);
    chk("R10 code 3 Y kept", pv(1), 16'h2FFF);
    chk("R10 code 3 Z kept", pv(2), 16'hFFF0);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    step();
    step();
    rst = 1'b0;
    t_reset();
    t_alu_rw();
    t_visibility();
    t_views();
    t_disp();
    t_postinc();
    t_predec();
    t_conflict();
    t_idle();
    done = 1'b1;
    finish_up();
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

endmodule